// File: doc/BRIEF.md
# Stacked Register Frame Remapper

This block maps the logical integer register numbers seen by software onto physical indices of a 128-entry integer register file. Logical registers 0 to 31 are global. They pass through unchanged and are visible at all times. Logical registers from 32 upward belong to the current procedure frame. That frame is a window of any size from 1 to 96 over a circular region of 96 physical registers. The window starts at a movable base, and its lowest part may additionally rotate for software-pipelined loops.

A frame is set up by an allocate command. The command gives the frame size, how many of the top registers of the frame are outputs, and how many of the bottom registers rotate. On a call, the base moves forward so that the caller's output registers become the callee's registers starting at logical 32. Arguments therefore cross the call without any data being copied. The old frame marker is pushed onto a small internal stack, and a return pops it. Each cycle, up to three logical registers are translated combinationally against the frame state held in registers.

Top module: `regframe_remap`

## Requirements
- R1: A lookup of a logical register below 32 returns the same number as the physical index, with the fault flag low.
- R2: A lookup of logical register 0 raises the zero flag and returns physical index 0; every other lookup leaves the zero flag low.
- R3: An allocate command sets the frame size, the output count and the rotating size, and it clears the rotation position. The command is ignored, leaving the state unchanged, if the size is 0 or above 96, if the output count exceeds the size, or if the rotating size exceeds the size.
- R4: A logical register r with 32 <= r < 32 + size maps to 32 + ((base + k) mod 96). Here k = r - 32 when r - 32 is not below the rotating size.
- R5: For r - 32 below the rotating size, k = (r - 32 + rotation position) mod rotating size. Each rotate command advances the position by one, modulo the rotating size. A rotate has no effect when the rotating size is 0.
- R6: A logical register at or above 32 + size raises the fault flag and returns physical index 0.
- R7: A call pushes the current frame marker. It then sets the base to (base + size - outputs) mod 96 and the size to the old output count, and it clears the output count, the rotating size and the rotation position.
- R8: A return pops the newest marker and restores its base, size, output count, rotating size and rotation position.
- R9: A call made while STK_DEPTH markers are already held changes nothing and raises the overflow flag for exactly the following cycle.
- R10: A return made with no marker held changes nothing and raises the underflow flag for exactly the following cycle.
- R11: Only one command acts per cycle, in the priority order return, call, allocate, rotate. Lookups in the same cycle as a command use the state from before that command.
- R12: After reset the base, size, output count, rotating size and rotation position are all 0, and the marker stack is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_vld | input | 1 | Allocate a new frame shape |
| alloc_size | input | 7 | Requested frame size |
| alloc_outs | input | 7 | Number of output registers at the top of the frame |
| alloc_rot | input | 7 | Number of rotating registers at the bottom of the frame |
| call_vld | input | 1 | Call: push the marker and shift the frame |
| ret_vld | input | 1 | Return: pop the marker |
| rot_vld | input | 1 | Advance the rotation by one |
| lk_reg | input | NLOOK*7 | Logical register numbers, lookup i in bits [7i+6:7i] |
| lk_phys | output | NLOOK*7 | Physical indices, packed the same way |
| lk_zero | output | NLOOK | Lookup i names the zero register |
| lk_fault | output | NLOOK | Lookup i lies outside the current frame |
| stk_ovf | output | 1 | The previous cycle's call found the stack full |
| stk_unf | output | 1 | The previous cycle's return found the stack empty |

## Verification
Two things can coincide in one cycle: a frame command, and lookups that must still see the frame from before the command. The bench issues calls, returns, allocations and rotations while all three lookups aim at registers whose mapping or fault status the command is about to change. Each result is compared with a behavioural model that updates only at the clock edge. Competing commands (return with call, call with allocate, allocate with rotate) are also driven in the same cycle. After each such cycle, lookups show which single command acted.

// File: rtl/regframe_pkg.sv
package regframe_pkg;
  localparam int unsigned NUM_REGS    = 128;
  localparam int unsigned NUM_GLOBAL  = 32;
  localparam int unsigned NUM_STACKED = NUM_REGS - NUM_GLOBAL;
  localparam int unsigned REG_W       = $clog2(NUM_REGS);
  localparam int unsigned CNT_W       = $clog2(NUM_STACKED + 1);

  // Saved/current frame description
  typedef struct packed {
    logic [CNT_W-1:0] base;   // physical offset of logical 32 within the stacked region
    logic [CNT_W-1:0] size;   // registers in the frame
    logic [CNT_W-1:0] outs;   // output registers at the top of the frame
    logic [CNT_W-1:0] rsz;    // rotating registers at the bottom of the frame
    logic [CNT_W-1:0] rpos;   // rotation position
  } frame_mark_t;
endpackage

// File: rtl/regframe_stack.sv
module regframe_stack
  import regframe_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push,
  input  logic        pop,
  input  frame_mark_t din,
  output frame_mark_t top,
  output logic        full,
  output logic        empty
);
  localparam int unsigned PW = $clog2(DEPTH + 1);

  logic [PW-1:0] cnt_q, cnt_d;
  frame_mark_t   slot_q [DEPTH];

  always_comb begin
    cnt_d = cnt_q;
    if (push)     cnt_d = cnt_q + PW'(1);
    else if (pop) cnt_d = cnt_q - PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (push || pop) cnt_q <= cnt_d;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic wr_en;
    assign wr_en = push && (cnt_q == PW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     slot_q[i] <= '0;
      else if (wr_en) slot_q[i] <= din;
    end
  end

  always_comb begin
    top = '0;
    for (int i = 0; i < DEPTH; i++)
      if (cnt_q == PW'(i + 1)) top = slot_q[i];
  end

  assign full  = (cnt_q == PW'(DEPTH));
  assign empty = (cnt_q == '0);
endmodule

// File: rtl/regframe_ctrl.sv
module regframe_ctrl
  import regframe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_vld,
  input  logic [CNT_W-1:0] alloc_size,
  input  logic [CNT_W-1:0] alloc_outs,
  input  logic [CNT_W-1:0] alloc_rot,
  input  logic             call_vld,
  input  logic             ret_vld,
  input  logic             rot_vld,
  input  frame_mark_t      stk_top,
  input  logic             stk_full,
  input  logic             stk_empty,
  output frame_mark_t      cur,
  output logic             push,
  output logic             pop,
  output logic             ovf,
  output logic             unf
);
  localparam logic [CNT_W:0] STK_N = (CNT_W+1)'(NUM_STACKED);

  frame_mark_t cur_q, cur_d;
  logic        upd, ovf_d, unf_d;
  logic [CNT_W:0] nb_sum;
  logic [CNT_W-1:0] rpos_inc;
  logic alloc_ok;

  // Base of a callee frame: skip the caller's non-output registers
  always_comb begin
    nb_sum = {1'b0, cur_q.base} + {1'b0, cur_q.size} - {1'b0, cur_q.outs};
    if (nb_sum >= STK_N) nb_sum = nb_sum - STK_N;
  end

  assign rpos_inc = (cur_q.rpos + CNT_W'(1) >= cur_q.rsz) ? '0 : cur_q.rpos + CNT_W'(1);

  assign alloc_ok = (alloc_size != '0) && ({1'b0, alloc_size} <= STK_N) &&
                    (alloc_outs <= alloc_size) && (alloc_rot <= alloc_size);

  always_comb begin
    cur_d = cur_q;
    upd   = 1'b0;
    push  = 1'b0;
    pop   = 1'b0;
    ovf_d = 1'b0;
    unf_d = 1'b0;
    if (ret_vld) begin
      if (stk_empty) unf_d = 1'b1;
      else begin
        pop   = 1'b1;
        upd   = 1'b1;
        cur_d = stk_top;
      end
    end else if (call_vld) begin
      if (stk_full) ovf_d = 1'b1;
      else begin
        push       = 1'b1;
        upd        = 1'b1;
        cur_d      = '0;
        cur_d.base = nb_sum[CNT_W-1:0];
        cur_d.size = cur_q.outs;
      end
    end else if (alloc_vld) begin
      if (alloc_ok) begin
        upd        = 1'b1;
        cur_d.size = alloc_size;
        cur_d.outs = alloc_outs;
        cur_d.rsz  = alloc_rot;
        cur_d.rpos = '0;
      end
    end else if (rot_vld) begin
      if (cur_q.rsz != '0) begin
        upd        = 1'b1;
        cur_d.rpos = rpos_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cur_q <= '0;
    else if (upd) cur_q <= cur_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf <= 1'b0;
      unf <= 1'b0;
    end else begin
      ovf <= ovf_d;
      unf <= unf_d;
    end
  end

  assign cur = cur_q;
endmodule

// File: rtl/regframe_xlat.sv
module regframe_xlat
  import regframe_pkg::*;
(
  input  frame_mark_t      cur,
  input  logic [REG_W-1:0] lreg,
  output logic [REG_W-1:0] phys,
  output logic             zero,
  output logic             fault
);
  localparam logic [REG_W-1:0] GLB   = REG_W'(NUM_GLOBAL);
  localparam logic [CNT_W:0]   STK_N = (CNT_W+1)'(NUM_STACKED);

  logic [CNT_W-1:0] off;
  logic [CNT_W:0]   rsum, psum;
  logic             glob;

  assign glob = lreg < GLB;
  assign off  = CNT_W'(lreg - GLB);

  // Second level: rotation inside the rotating sub-region
  always_comb begin
    if (off < cur.rsz) begin
      rsum = {1'b0, off} + {1'b0, cur.rpos};
      if (rsum >= {1'b0, cur.rsz}) rsum = rsum - {1'b0, cur.rsz};
    end else begin
      rsum = {1'b0, off};
    end
    // First level: frame base, wrapping around the stacked region
    psum = {1'b0, cur.base} + rsum;
    if (psum >= STK_N) psum = psum - STK_N;
  end

  always_comb begin
    zero  = (lreg == '0);
    fault = 1'b0;
    if (glob) phys = lreg;
    else if (off >= cur.size) begin
      fault = 1'b1;
      phys  = '0;
    end else phys = GLB + REG_W'(psum);
  end
endmodule

// File: rtl/regframe_remap.sv
module regframe_remap
  import regframe_pkg::*;
#(
  parameter int unsigned NLOOK     = 3,
  parameter int unsigned STK_DEPTH = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   alloc_vld,
  input  logic [CNT_W-1:0]       alloc_size,
  input  logic [CNT_W-1:0]       alloc_outs,
  input  logic [CNT_W-1:0]       alloc_rot,
  input  logic                   call_vld,
  input  logic                   ret_vld,
  input  logic                   rot_vld,
  input  logic [NLOOK*REG_W-1:0] lk_reg,
  output logic [NLOOK*REG_W-1:0] lk_phys,
  output logic [NLOOK-1:0]       lk_zero,
  output logic [NLOOK-1:0]       lk_fault,
  output logic                   stk_ovf,
  output logic                   stk_unf
);
  logic [1:0]  rst_q;
  logic        rst_i_n;
  frame_mark_t cur, stk_top;
  logic        push, pop, full, empty;

  // Reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_i_n = rst_q[1];

  regframe_stack #(.DEPTH(STK_DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_i_n), .push(push), .pop(pop), .din(cur),
    .top(stk_top), .full(full), .empty(empty)
  );

  regframe_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_i_n),
    .alloc_vld(alloc_vld), .alloc_size(alloc_size), .alloc_outs(alloc_outs),
    .alloc_rot(alloc_rot), .call_vld(call_vld), .ret_vld(ret_vld),
    .rot_vld(rot_vld), .stk_top(stk_top), .stk_full(full), .stk_empty(empty),
    .cur(cur), .push(push), .pop(pop), .ovf(stk_ovf), .unf(stk_unf)
  );

  for (genvar i = 0; i < NLOOK; i++) begin : g_look
    regframe_xlat u_xlat (
      .cur(cur),
      .lreg(lk_reg[i*REG_W +: REG_W]),
      .phys(lk_phys[i*REG_W +: REG_W]),
      .zero(lk_zero[i]),
      .fault(lk_fault[i])
    );
  end
endmodule

// File: rtl/regframe_sva.sv
module regframe_sva
  import regframe_pkg::*;
#(
  parameter int unsigned NLOOK = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   call_vld,
  input logic                   ret_vld,
  input logic [NLOOK*REG_W-1:0] lk_reg,
  input logic [NLOOK*REG_W-1:0] lk_phys,
  input logic [NLOOK-1:0]       lk_zero,
  input logic [NLOOK-1:0]       lk_fault,
  input logic                   stk_ovf,
  input logic                   stk_unf
);
  for (genvar i = 0; i < NLOOK; i++) begin : g_chk
    logic [REG_W-1:0] r, p;
    assign r = lk_reg[i*REG_W +: REG_W];
    assign p = lk_phys[i*REG_W +: REG_W];

    p_global_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (r < REG_W'(NUM_GLOBAL)) |-> (p == r) && !lk_fault[i]);

    p_zero_reg_r2: assert property (@(posedge clk) disable iff (!rst_n)
      lk_zero[i] |-> (r == '0) && (p == '0));

    p_stacked_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((r >= REG_W'(NUM_GLOBAL)) && !lk_fault[i]) |-> (p >= REG_W'(NUM_GLOBAL)));

    p_fault_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
      lk_fault[i] |-> (r >= REG_W'(NUM_GLOBAL)) && (p == '0));
  end

  p_ovf_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stk_ovf |-> $past(call_vld && !ret_vld));

  p_unf_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stk_unf |-> $past(ret_vld));

  p_one_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(stk_ovf && stk_unf));
endmodule

bind regframe_remap regframe_sva #(.NLOOK(NLOOK)) u_sva (
  .clk(clk), .rst_n(rst_n), .call_vld(call_vld), .ret_vld(ret_vld),
  .lk_reg(lk_reg), .lk_phys(lk_phys), .lk_zero(lk_zero), .lk_fault(lk_fault),
  .stk_ovf(stk_ovf), .stk_unf(stk_unf)
);

// File: tb/regframe_remap_bench.sv
`timescale 1ns/1ps
module regframe_remap_bench;
  localparam int NL = 3;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_vld = 0, call_vld = 0, ret_vld = 0, rot_vld = 0;
  logic [6:0] alloc_size = 0, alloc_outs = 0, alloc_rot = 0;
  logic [NL*7-1:0] lk_reg = '0;
  logic [NL*7-1:0] lk_phys;
  logic [NL-1:0] lk_zero, lk_fault;
  logic stk_ovf, stk_unf;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  int m_base = 0, m_size = 0, m_outs = 0, m_rsz = 0, m_rpos = 0;
  int q_base[$], q_size[$], q_outs[$], q_rsz[$], q_rpos[$];
  bit e_ovf = 0, e_unf = 0;

  always #5 clk = ~clk;

  regframe_remap #(.NLOOK(NL), .STK_DEPTH(DEPTH)) u_regframe_remap (
    .clk(clk), .rst_n(rst_n), .alloc_vld(alloc_vld), .alloc_size(alloc_size),
    .alloc_outs(alloc_outs), .alloc_rot(alloc_rot), .call_vld(call_vld),
    .ret_vld(ret_vld), .rot_vld(rot_vld), .lk_reg(lk_reg), .lk_phys(lk_phys),
    .lk_zero(lk_zero), .lk_fault(lk_fault), .stk_ovf(stk_ovf), .stk_unf(stk_unf)
  );

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int ref_phys(int r, output bit flt);
    int off, k;
    flt = 0;
    if (r < 32) return r;
    off = r - 32;
    if (off >= m_size) begin flt = 1; return 0; end
    k = (off < m_rsz) ? (off + m_rpos) % m_rsz : off;
    return 32 + ((m_base + k) % 96);
  endfunction

  function automatic string tag_of(int r);
    int off;
    if (r == 0) return "R2";
    if (r < 32) return "R1";
    off = r - 32;
    if (off >= m_size) return "R6";
    if (off < m_rsz) return "R5";
    return "R4";
  endfunction

  // One cycle: drive at the falling edge, compare, then advance the model at the rising edge
  task automatic cyc(bit rt, bit cl, bit al, bit ro, int asz, int aou, int arot,
                     int l0, int l1, int l2, string ctx);
    int lr[3];
    @(negedge clk);
    ret_vld = rt; call_vld = cl; alloc_vld = al; rot_vld = ro;
    alloc_size = 7'(asz); alloc_outs = 7'(aou); alloc_rot = 7'(arot);
    lr[0] = l0; lr[1] = l1; lr[2] = l2;
    for (int i = 0; i < NL; i++) lk_reg[i*7 +: 7] = 7'(lr[i]);
    #1;
    for (int i = 0; i < NL; i++) begin
      bit f; int p;
      p = ref_phys(lr[i], f);
      check({tag_of(lr[i]), " ", ctx}, $sformatf("phys of r%0d", lr[i]), int'(lk_phys[i*7 +: 7]), p);
      check({(f ? "R6 " : "R4 "), ctx}, $sformatf("fault of r%0d", lr[i]), int'(lk_fault[i]), int'(f));
      check({"R2 ", ctx}, $sformatf("zero of r%0d", lr[i]), int'(lk_zero[i]), int'(lr[i] == 0));
    end
    check({"R9 ", ctx}, "overflow flag", int'(stk_ovf), int'(e_ovf));
    check({"R10 ", ctx}, "underflow flag", int'(stk_unf), int'(e_unf));
    @(posedge clk);
    e_ovf = 0; e_unf = 0;
    if (rt) begin
      if (q_base.size() == 0) e_unf = 1;
      else begin
        m_base = q_base.pop_back(); m_size = q_size.pop_back(); m_outs = q_outs.pop_back();
        m_rsz = q_rsz.pop_back(); m_rpos = q_rpos.pop_back();
      end
    end else if (cl) begin
      if (q_base.size() == DEPTH) e_ovf = 1;
      else begin
        q_base.push_back(m_base); q_size.push_back(m_size); q_outs.push_back(m_outs);
        q_rsz.push_back(m_rsz); q_rpos.push_back(m_rpos);
        m_base = (m_base + m_size - m_outs) % 96;
        m_size = m_outs; m_outs = 0; m_rsz = 0; m_rpos = 0;
      end
    end else if (al) begin
      if (asz >= 1 && asz <= 96 && aou <= asz && arot <= asz) begin
        m_size = asz; m_outs = aou; m_rsz = arot; m_rpos = 0;
      end
    end else if (ro) begin
      if (m_rsz > 0) m_rpos = (m_rpos + 1) % m_rsz;
    end
  endtask

  task automatic idle(int l0, int l1, int l2, string ctx);
    cyc(0, 0, 0, 0, 0, 0, 0, l0, l1, l2, ctx);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12: empty frame after reset, globals pass, r32 faults
    idle(0, 5, 32, "R12 reset state");
    cyc(1, 0, 0, 0, 0, 0, 0, 31, 32, 0, "R12 empty stack");   // R10 underflow
    idle(1, 2, 3, "R10 flag pulse");
    idle(1, 2, 3, "R10 flag clears");

    // R3: allocate and out-of-range fault boundary
    cyc(0, 0, 1, 0, 10, 3, 0, 32, 41, 42, "R3 alloc");
    idle(32, 41, 42, "R3 R6 frame edge");
    cyc(0, 0, 1, 0, 0, 0, 0, 41, 42, 0, "R3 size zero");
    cyc(0, 0, 1, 0, 97, 0, 0, 41, 42, 0, "R3 size too big");
    cyc(0, 0, 1, 0, 5, 6, 0, 41, 42, 0, "R3 outs over size");
    cyc(0, 0, 1, 0, 5, 0, 6, 41, 42, 0, "R3 rot over size");
    idle(36, 41, 42, "R3 ignored allocs");

    // R7 with R11: lookups in the call cycle see the caller frame
    cyc(0, 1, 0, 0, 0, 0, 0, 39, 41, 35, "R11 call cycle");
    idle(32, 34, 35, "R7 callee sees caller outputs");
    cyc(0, 0, 1, 0, 8, 2, 4, 32, 39, 40, "R3 callee alloc");
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 1, 0, 0, 0, 32, 33, 35, "R5 rotate");
    idle(36, 38, 39, "R5 non-rotating part");
    cyc(1, 1, 0, 0, 0, 0, 0, 32, 33, 36, "R11 ret beats call");
    idle(32, 41, 42, "R8 restored");
    cyc(0, 0, 1, 1, 20, 4, 5, 32, 50, 60, "R11 alloc beats rotate");
    cyc(0, 1, 1, 0, 30, 4, 0, 32, 50, 52, "R11 call beats alloc");
    idle(32, 35, 36, "R7 second call");
    cyc(1, 0, 0, 0, 0, 0, 0, 32, 36, 0, "R8 ret");

    // Wrap of the base around the stacked region (R4)
    cyc(0, 0, 1, 0, 96, 1, 0, 32, 127, 100, "R4 full frame");
    cyc(0, 1, 0, 0, 0, 0, 0, 127, 32, 33, "R7 call to top");
    idle(32, 33, 0, "R4 base 95");
    cyc(0, 0, 1, 0, 10, 10, 3, 32, 33, 40, "R4 wrap alloc");
    idle(32, 33, 41, "R4 wrap lookup");

    // R9: fill the stack then overflow
    for (int i = 0; i < 5; i++) cyc(0, 1, 0, 0, 0, 0, 0, 32, 33, 34, "R9 calls");
    idle(32, 33, 34, "R9 after overflow");
    for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0, 0, 0, 0, 32, 40, 50, "R8 unwind");
    idle(32, 40, 50, "R10 after unwind");

    // Mixed random traffic
    for (int n = 0; n < 3000; n++) begin
      int sel, l[3];
      sel = $urandom_range(0, 19);
      for (int i = 0; i < 3; i++) begin
        if ($urandom_range(0, 3) == 0) l[i] = $urandom_range(0, 127);
        else l[i] = 32 + $urandom_range(0, m_size + 1);
        if (l[i] > 127) l[i] = 127;
      end
      cyc(sel == 0 || sel == 5, sel == 1 || sel == 5 || sel == 6, sel == 2 || sel == 6 || sel == 7,
          sel >= 7 && sel <= 12,
          $urandom_range(0, 100), $urandom_range(0, 40), $urandom_range(0, 40),
          l[0], l[1], l[2], "R11 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule